// File: doc/BRIEF.md
# Calibration Pattern Read Path

This block is the read-data path of a DDR3 memory device when its multipurpose calibration register is in play. It samples read commands with their address and bank bits, waits the configured CAS read latency, and then drives a burst of 8 or a chopped burst of 4 onto the data lines. While calibration readout is enabled it replaces array data with a fixed alternating 0,1 pattern that a controller uses to train its read capture. While calibration readout is disabled it forwards the array data presented on `arrayData` beat by beat.

The burst length comes from the burst configuration field of mode register 0, and from address bit A12 when that field selects on-the-fly choice. Address bit A2 picks the nibble of a chopped burst. A calibration read with nonzero low address bits, or with a reserved page code in mode register 3, still runs a full-length burst, but it drives all lanes low and raises `rdErr`. The configuration inputs are sampled when a read is accepted. A read that arrives while an earlier read is still pending or bursting is dropped.

Top module: `mpr_calib_readout`

## Requirements
- R1: After reset, and until a read is accepted, `dqValid` and `rdErr` are 0 and `dqOut` is all zeros.
- R2: A read is accepted on the rising edge at which `rdCmd` is 1 and the block is idle. `dqValid` is 1 for the first beat in the cycle that follows the edge `casLat` edges later (`casLat` of 1 to 15). A value of 0 behaves as 1.
- R3: The beat count is 8 when `burstMode` is 2'b00 or 2'b11, and 4 when `burstMode` is 2'b10. `dqValid` stays high for exactly that many consecutive cycles.
- R4: When `burstMode` is 2'b01, the choice is made per read: A12 = 1 gives 8 beats and A12 = 0 gives 4 beats.
- R5: A calibration read is one with `mr3Cfg[2]` = 1. It is valid when `mr3Cfg[1:0]` = 2'b00 and A[1:0] = 2'b00. On beat k (counting from 0) it carries the bit k mod 2, giving 0,1,0,1,... `arrayData` has no effect.
- R6: In a chopped calibration burst, A2 = 0 selects burst-order positions 0 to 3 and A2 = 1 selects positions 4 to 7. A full burst always runs positions 0 to 7, whatever A2 is. In every case the data seen is 0,1,0,1,...
- R7: When `allLanes` = 1, every lane of `dqOut` carries the pattern bit. When `allLanes` = 0, only lane 0 carries it and the other lanes are 0.
- R8: A calibration read with A[1:0] not equal to 2'b00, or with `mr3Cfg[1:0]` not equal to 2'b00, keeps its normal burst length. During each of its beats, `rdErr` is 1 and `dqOut` is all zeros.
- R9: When `mr3Cfg[2]` = 0, each beat drives `dqOut` equal to `arrayData` in that cycle. `rdErr` stays 0, and A[1:0] is not checked.
- R10: A[11:3], A13 and `rdBank` have no effect on a calibration read. A12 has no effect unless `burstMode` is 2'b01.
- R11: A read command that arrives while an earlier read is waiting out its latency or bursting is dropped. The running burst is neither lengthened nor restarted, and no second burst follows it.
- R12: Outside burst beats, `dqOut` is all zeros and `rdErr` is 0.
- R13: `mr3Cfg`, `burstMode`, `allLanes` and `casLat` are sampled when a read is accepted. Changing them during the latency wait or the burst does not alter that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| mr3Cfg | input | 3 | Bit 2 enables calibration readout; bits 1:0 select the page (only 2'b00 is defined) |
| burstMode | input | 2 | Burst length field: 00 fixed 8, 01 chosen by A12, 10 fixed chop 4, 11 treated as 8 |
| allLanes | input | 1 | 1: pattern on all lanes; 0: pattern on lane 0 only |
| casLat | input | LAT_W (4) | Read latency in cycles |
| rdCmd | input | 1 | Read command strobe |
| rdAddr | input | ADDR_W (14) | Column address bits A[13:0] of the read |
| rdBank | input | BANK_W (3) | Bank address of the read |
| arrayData | input | DQ_W (4) | Array read data for the current beat |
| dqOut | output | DQ_W (4) | Data lines |
| dqValid | output | 1 | High during each burst beat |
| rdErr | output | 1 | High during beats of an illegal calibration read |

## Verification
Some behaviours are checked by assertions on every cycle. These are the spacing from acceptance to the first beat, the 4-or-8 run length of `dqValid`, silent lanes outside beats and on erroneous reads, and lane uniformity in all-lanes mode. Other behaviours only show up in the bench's scenarios, where each read is compared cycle by cycle with an expected burst. These are the pattern values per beat, the selection among burst modes by A12, pass-through of array data, the ignored address and bank bits, dropped overlapping reads, and sampling of the configuration at acceptance.

// File: rtl/mpr_read_pkg.sv
package mpr_read_pkg;

  localparam int BEATS_FULL = 8;
  localparam int BEATS_CHOP = 4;
  localparam int ORDER_W    = $clog2(BEATS_FULL);

  typedef enum logic [1:0] {
    BM_FIXED8 = 2'b00,
    BM_ON_FLY = 2'b01,
    BM_FIXED4 = 2'b10,
    BM_RSVD   = 2'b11
  } burstMode_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_WAIT  = 2'b01,
    ST_BURST = 2'b10
  } rdState_e;

  // strobes from control to datapath, one set per cycle
  typedef struct packed {
    logic               beatOn;
    logic               calMode;
    logic               errFlag;
    logic               laneAll;
    logic [ORDER_W-1:0] orderIdx;
  } beatStrobe_t;

  // burst chop decision; a12 only matters in on-the-fly mode
  function automatic logic isChopped(input logic [1:0] mode, input logic a12);
    case (burstMode_e'(mode))
      BM_FIXED4: isChopped = 1'b1;
      BM_ON_FLY: isChopped = ~a12;
      default:   isChopped = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/mpr_read_ctrl.sv
module mpr_read_ctrl
  import mpr_read_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mr3Cfg,
  input  logic [1:0]        burstMode,
  input  logic              allLanes,
  input  logic [LAT_W-1:0]  casLat,
  input  logic              rdCmd,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BANK_W-1:0] rdBank,
  output beatStrobe_t       strobe
);

  localparam int CNT_W = LAT_W + 1;
  localparam logic [ORDER_W-1:0] LAST_FULL = ORDER_W'(BEATS_FULL - 1);
  localparam logic [ORDER_W-1:0] LAST_CHOP = ORDER_W'(BEATS_CHOP - 1);

  rdState_e           state;
  logic [LAT_W-1:0]   latCnt;
  logic [ORDER_W-1:0] beat;
  logic               chopQ;
  logic               hiNibQ;
  logic               calQ;
  logic               errQ;
  logic               lanesQ;
  logic [LAT_W-1:0]   latClQ;

  logic               accept;
  logic               chopNow;
  logic               errNow;
  logic [LAT_W-1:0]   effCl;
  logic [ORDER_W-1:0] lastBeat;

  // bits the calibration read never looks at
  logic unusedAddrBits;
  assign unusedAddrBits = ^{rdAddr[ADDR_W-1:13], rdAddr[11:3], rdBank};

  assign accept   = rdCmd && (state == ST_IDLE);
  assign chopNow  = isChopped(burstMode, rdAddr[12]);
  assign errNow   = mr3Cfg[2] && ((mr3Cfg[1:0] != 2'b00) || (rdAddr[1:0] != 2'b00));
  assign effCl    = (casLat == '0) ? LAT_W'(1) : casLat;
  assign lastBeat = chopQ ? LAST_CHOP : LAST_FULL;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      latCnt <= '0;
      beat   <= '0;
      chopQ  <= 1'b0;
      hiNibQ <= 1'b0;
      calQ   <= 1'b0;
      errQ   <= 1'b0;
      lanesQ <= 1'b0;
      latClQ <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_WAIT;
            latCnt <= effCl;
            chopQ  <= chopNow;
            hiNibQ <= rdAddr[2];
            calQ   <= mr3Cfg[2];
            errQ   <= errNow;
            lanesQ <= allLanes;
            latClQ <= effCl;
          end
        end
        ST_WAIT: begin
          if (latCnt == LAT_W'(1)) begin
            state <= ST_BURST;
            beat  <= '0;
          end else begin
            latCnt <= latCnt - LAT_W'(1);
          end
        end
        ST_BURST: begin
          if (beat == lastBeat) begin
            state <= ST_IDLE;
          end else begin
            beat <= beat + ORDER_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // a full burst always starts at position 0; a chop picks its nibble by A2
  always_comb begin
    strobe.beatOn   = (state == ST_BURST);
    strobe.calMode  = calQ;
    strobe.errFlag  = errQ;
    strobe.laneAll  = lanesQ;
    strobe.orderIdx = chopQ ? {hiNibQ, beat[ORDER_W-2:0]} : beat;
  end

  // ---------------- checking counters ----------------
  logic [CNT_W-1:0] sinceCap;
  logic [3:0]       runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceCap <= '0;
      runLen   <= '0;
    end else begin
      if (accept)
        sinceCap <= '0;
      else if (state != ST_IDLE && sinceCap != '1)
        sinceCap <= sinceCap + CNT_W'(1);
      runLen <= strobe.beatOn ? runLen + 4'd1 : 4'd0;
    end
  end

  // R2: first beat arrives exactly the latched latency after acceptance
  assert_first_beat_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobe.beatOn) |-> (sinceCap == CNT_W'(latClQ)));

  // R3: each burst runs for 4 or 8 beats according to its chop decision
  assert_burst_length_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe.beatOn) |-> (runLen == (chopQ ? 4'(BEATS_CHOP) : 4'(BEATS_FULL))));

endmodule

// File: rtl/mpr_read_dpath.sv
module mpr_read_dpath
  import mpr_read_pkg::*;
#(
  parameter int DQ_W = 4
) (
  input  logic            clk,
  input  logic            rstN,
  input  beatStrobe_t     strobe,
  input  logic [DQ_W-1:0] arrayData,
  output logic [DQ_W-1:0] dqOut,
  output logic            dqValid,
  output logic            rdErr
);

  // pattern bit depends only on the parity of the burst-order position
  logic patBit;
  logic unusedOrder;
  assign patBit      = strobe.orderIdx[0];
  assign unusedOrder = ^strobe.orderIdx[ORDER_W-1:1];

  for (genvar lane = 0; lane < DQ_W; lane++) begin : g_lane
    logic laneCarries;
    if (lane == 0) begin : g_primary
      assign laneCarries = 1'b1;
    end else begin : g_secondary
      assign laneCarries = strobe.laneAll;
    end

    always_comb begin
      if (!strobe.beatOn)
        dqOut[lane] = 1'b0;
      else if (!strobe.calMode)
        dqOut[lane] = arrayData[lane];
      else if (strobe.errFlag)
        dqOut[lane] = 1'b0;
      else
        dqOut[lane] = laneCarries & patBit;
    end
  end

  assign dqValid = strobe.beatOn;
  assign rdErr   = strobe.beatOn & strobe.calMode & strobe.errFlag;

  // R8: an erroneous calibration beat drives nothing
  assert_err_lanes_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    rdErr |-> (dqOut == '0));

  // R12: quiet outside beats
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rstN)
    !dqValid |-> ((dqOut == '0) && !rdErr));

  // R7: all lanes agree when the pattern is broadcast
  assert_lanes_uniform_R7: assert property (@(posedge clk) disable iff (!rstN)
    (dqValid && strobe.calMode && !strobe.errFlag && strobe.laneAll) |->
      ((dqOut == '0) || (dqOut == '1)));

endmodule

// File: rtl/mpr_calib_readout.sv
module mpr_calib_readout
  import mpr_read_pkg::*;
#(
  parameter int DQ_W   = 4,
  parameter int ADDR_W = 14,
  parameter int BANK_W = 3,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        mr3Cfg,
  input  logic [1:0]        burstMode,
  input  logic              allLanes,
  input  logic [LAT_W-1:0]  casLat,
  input  logic              rdCmd,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [BANK_W-1:0] rdBank,
  input  logic [DQ_W-1:0]   arrayData,
  output logic [DQ_W-1:0]   dqOut,
  output logic              dqValid,
  output logic              rdErr
);

  beatStrobe_t strobe;

  mpr_read_ctrl #(
    .ADDR_W(ADDR_W),
    .BANK_W(BANK_W),
    .LAT_W (LAT_W)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .mr3Cfg   (mr3Cfg),
    .burstMode(burstMode),
    .allLanes (allLanes),
    .casLat   (casLat),
    .rdCmd    (rdCmd),
    .rdAddr   (rdAddr),
    .rdBank   (rdBank),
    .strobe   (strobe)
  );

  mpr_read_dpath #(
    .DQ_W(DQ_W)
  ) dpath_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .arrayData(arrayData),
    .dqOut    (dqOut),
    .dqValid  (dqValid),
    .rdErr    (rdErr)
  );

endmodule

// File: tb/mpr_calib_readout_tb.sv
`timescale 1ns/1ps
module mpr_calib_readout_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  mr3Cfg = '0;
  logic [1:0]  burstMode = '0;
  logic        allLanes = 1'b0;
  logic [3:0]  casLat = 4'd5;
  logic        rdCmd = 1'b0;
  logic [13:0] rdAddr = '0;
  logic [2:0]  rdBank = '0;
  logic [3:0]  arrayData = '0;
  logic [3:0]  dqOut;
  logic        dqValid;
  logic        rdErr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mpr_calib_readout dut_i (
    .clk(clk), .rstN(rstN), .mr3Cfg(mr3Cfg), .burstMode(burstMode),
    .allLanes(allLanes), .casLat(casLat), .rdCmd(rdCmd), .rdAddr(rdAddr),
    .rdBank(rdBank), .arrayData(arrayData), .dqOut(dqOut),
    .dqValid(dqValid), .rdErr(rdErr)
  );

  typedef struct packed {
    logic [2:0]  mr3;
    logic [1:0]  bm;
    logic        lanes;
    logic [3:0]  cl;
    logic [13:0] addr;
    logic [2:0]  bank;
    logic [3:0]  len;
    logic        err;
    logic [1:0]  mode;   // 0 plain, 1 config change mid-read, 2 extra read commands
    logic [3:0]  tag;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{3'b100, 2'b00, 1'b1, 4'd5, 14'h0000, 3'd0, 4'd8, 1'b0, 2'd0, 4'd5},  // R5 full
    '{3'b100, 2'b10, 1'b1, 4'd5, 14'h0000, 3'd1, 4'd4, 1'b0, 2'd0, 4'd3},  // R3 fixed chop
    '{3'b100, 2'b01, 1'b1, 4'd6, 14'h1000, 3'd2, 4'd8, 1'b0, 2'd0, 4'd4},  // R4 A12=1
    '{3'b100, 2'b01, 1'b0, 4'd6, 14'h0004, 3'd3, 4'd4, 1'b0, 2'd0, 4'd4},  // R4 A12=0
    '{3'b100, 2'b10, 1'b0, 4'd3, 14'h0004, 3'd4, 4'd4, 1'b0, 2'd0, 4'd6},  // R6 upper nibble
    '{3'b100, 2'b00, 1'b1, 4'd4, 14'h0004, 3'd0, 4'd8, 1'b0, 2'd0, 4'd6},  // R6 A2 in full
    '{3'b100, 2'b00, 1'b1, 4'd5, 14'h3FF8, 3'd5, 4'd8, 1'b0, 2'd0, 4'd10}, // R10 junk bits
    '{3'b100, 2'b00, 1'b1, 4'd5, 14'h0001, 3'd0, 4'd8, 1'b1, 2'd0, 4'd8},  // R8 A0
    '{3'b100, 2'b10, 1'b1, 4'd5, 14'h0002, 3'd0, 4'd4, 1'b1, 2'd0, 4'd8},  // R8 A1 chop
    '{3'b101, 2'b00, 1'b1, 4'd5, 14'h0000, 3'd0, 4'd8, 1'b1, 2'd0, 4'd8},  // R8 page 01
    '{3'b110, 2'b01, 1'b1, 4'd5, 14'h0000, 3'd0, 4'd4, 1'b1, 2'd0, 4'd8},  // R8 page 10
    '{3'b000, 2'b00, 1'b1, 4'd5, 14'h0000, 3'd0, 4'd8, 1'b0, 2'd0, 4'd9},  // R9 pass
    '{3'b000, 2'b01, 1'b0, 4'd2, 14'h0003, 3'd7, 4'd4, 1'b0, 2'd0, 4'd9},  // R9 low bits ok
    '{3'b100, 2'b00, 1'b0, 4'd1, 14'h0000, 3'd0, 4'd8, 1'b0, 2'd0, 4'd2},  // R2 CL 1
    '{3'b100, 2'b11, 1'b1, 4'd4, 14'h0000, 3'd0, 4'd8, 1'b0, 2'd0, 4'd3},  // R3 reserved mode
    '{3'b100, 2'b00, 1'b1, 4'd3, 14'h0000, 3'd0, 4'd8, 1'b0, 2'd1, 4'd13}, // R13
    '{3'b100, 2'b10, 1'b1, 4'd4, 14'h0000, 3'd0, 4'd4, 1'b0, 2'd2, 4'd11}, // R11 cal
    '{3'b000, 2'b00, 1'b1, 4'd3, 14'h0000, 3'd0, 4'd8, 1'b0, 2'd2, 4'd11}, // R11 pass
    '{3'b100, 2'b00, 1'b0, 4'd7, 14'h0000, 3'd0, 4'd8, 1'b0, 2'd0, 4'd7}   // R7 lane 0 only
  };

  function automatic string tagName(input logic [3:0] t);
    case (t)
      4'd2:  tagName = "R2";
      4'd3:  tagName = "R3";
      4'd4:  tagName = "R4";
      4'd5:  tagName = "R5";
      4'd6:  tagName = "R6";
      4'd7:  tagName = "R7";
      4'd8:  tagName = "R8";
      4'd9:  tagName = "R9";
      4'd10: tagName = "R10";
      4'd11: tagName = "R11";
      4'd13: tagName = "R13";
      default: tagName = "R1";
    endcase
  endfunction

  task automatic checkOut(input string tag, input int cyc, input logic expV,
                          input logic [3:0] expD, input logic expE);
    checks++;
    if (dqValid !== expV || dqOut !== expD || rdErr !== expE) begin
      errors++;
      $display("FAIL %s cycle %0d: valid/data/err = %b/%h/%b expected %b/%h/%b",
               tag, cyc, dqValid, dqOut, rdErr, expV, expD, expE);
    end
  endtask

  task automatic runRead(input vec_t v);
    int lenI = int'(v.len);
    int clI  = int'(v.cl);
    @(negedge clk);
    mr3Cfg = v.mr3; burstMode = v.bm; allLanes = v.lanes; casLat = v.cl;
    rdAddr = v.addr; rdBank = v.bank; rdCmd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rdCmd = 1'b0;
    rdAddr = 14'h0ABC;
    for (int j = 1; j <= clI + lenI + 10; j++) begin
      logic inBeat;
      logic bitV;
      logic [3:0] expD;
      logic expE;
      string tag;
      @(negedge clk);
      rdCmd = (v.mode == 2'd2) && (j == 2 || j == clI + 2);
      if (v.mode == 2'd1 && j == clI + 1) begin
        allLanes = ~v.lanes; mr3Cfg = 3'b000; burstMode = 2'b10; casLat = 4'd1;
      end
      arrayData = 4'((j * 5 + 3) & 15);
      #1;
      inBeat = (j >= clI) && (j < clI + lenI);
      bitV   = 1'((j - clI) & 1);
      if (!inBeat)
        expD = 4'h0;
      else if (!v.mr3[2])
        expD = arrayData;
      else if (v.err)
        expD = 4'h0;
      else
        expD = v.lanes ? {4{bitV}} : {3'b000, bitV};
      expE = inBeat && v.mr3[2] && v.err;
      // beat timing mismatches belong to R2 R3; quiet cycles to R12
      tag = inBeat ? tagName(v.tag) : "R12";
      if (dqValid !== inBeat) tag = {tag, " R2 R3"};
      checkOut(tag, j, inBeat, expD, expE);
    end
    rdCmd = 1'b0;
  endtask

  initial begin
    // R1: reset state, during and right after reset
    #2;
    checkOut("R1", 0, 1'b0, 4'h0, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkOut("R1", 1, 1'b0, 4'h0, 1'b0);
    for (int i = 0; i < NV; i++) runRead(VECS[i]);
    // R1: reset in the middle of a burst returns to quiet state
    @(negedge clk);
    mr3Cfg = 3'b100; burstMode = 2'b00; allLanes = 1'b1; casLat = 4'd2;
    rdAddr = '0; rdCmd = 1'b1;
    @(negedge clk);
    rdCmd = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b0;
    #1;
    checkOut("R1", 2, 1'b0, 4'h0, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (12) @(negedge clk);
    checkOut("R1", 3, 1'b0, 4'h0, 1'b0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule